// File: doc/BRIEF.md
# EDO Read Output Enable Control

This block decides, one clock at a time, whether each byte lane of a 16-bit DRAM read bus drives data or stays in high impedance. It also decides when the read word is captured and when it is held. It samples the row strobe, two per-lane column strobes, an output-gate strobe and the write strobe synchronously, all active low. The read output holds after its column strobe rises and is dropped only by an explicit release condition. This extended-data-out behaviour applies to single reads, page-mode reads and read-modify-write cycles.

The block also tracks refresh cycles. A row strobe that falls while a column strobe is already low starts a refresh, and no read may start until the row strobe rises again. A read that is already being driven survives a hidden refresh, where the column strobe stays low while the row strobe is cycled. A row-strobe-only refresh leaves the bus in high impedance. In page mode a column-address-valid pulse refreshes the held word early, before the next column strobe falls.

Top module: `edo_read_ctl`

## Requirements
- R1: After reset both lane enables are 0 and the held data word is 0.
- R2: A lane is enabled, and its byte is captured from `rd_data` at the same edge, at the first clock edge where all of the following hold: its column strobe is sampled low after being sampled high; `ras_n`, `outen_n` are low; `we_n` is high; and the current row cycle is not a refresh. Lane 0 uses `cas_n[0]` and bits 7:0. Lane 1 uses `cas_n[1]` and bits 15:8.
- R3: An enabled lane stays enabled with unchanged data after its column strobe returns high while `ras_n` stays low, as long as no release condition is sampled.
- R4: An enabled lane is disabled at the next clock edge after any one of these is sampled: `we_n` low, `outen_n` high, or the lane's column strobe high together with `ras_n` high.
- R5: Within one row cycle, each new falling column strobe that meets the R2 conditions recaptures that lane's byte.
- R6: Once a read access has occurred in the current row-low period, `col_vld` high at a clock edge recaptures the byte of every enabled lane, without a column strobe edge. Outside such a period, `col_vld` has no effect.
- R7: A falling column strobe with `we_n` low, `outen_n` high or `ras_n` high does not enable the lane.
- R8: A row strobe falling while any column strobe is already low (sampled low at the previous edge too) marks a refresh. Until `ras_n` is sampled high again, no column strobe fall enables a lane.
- R9: Hidden refresh: if a lane is enabled and its column strobe stays low while `ras_n` rises and falls again, the lane stays enabled with its data unchanged.
- R10: Cycling `ras_n` with both column strobes high never enables a lane.
- R11: Read-modify-write: data captured in a read stays driven after the column strobe rises. It is released at the edge after `we_n` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 2 | Per-lane column strobes, active low, bit 0 = lane 0 |
| outen_n | input | 1 | Output gate strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| col_vld | input | 1 | Column address valid pulse for early page-mode capture |
| rd_data | input | 16 | Read word from the array |
| dq_out | output | 16 | Held read word |
| dq_oe | output | 2 | Per-lane output enable |

## Verification
The hardest situation to reach is a hidden refresh that follows a live read. The lane must already be enabled with its column strobe held low. The row strobe must then rise and fall with no release condition seen, so that the second row fall is classed as a refresh while the old word stays on the bus. The stimulus builds this on purpose. It first runs a standalone refresh cycle to show that reads are blocked. It then starts a normal read and, without raising the column strobe, cycles the row strobe twice. It feeds a different `rd_data` value during the refresh, so any stray recapture is visible.

// File: rtl/edo_pkg.sv
// Package: shared types and helpers for the EDO read output control.
// Assumes all strobes are active low and sampled on the rising clock edge.
package edo_pkg;

    // Strobes common to every byte lane, grouped for port economy.
    typedef struct packed {
        logic ras_n;
        logic outen_n;
        logic we_n;
        logic col_vld;
    } edo_strobe_t;

    // A lane must let go of the bus when any of these holds.
    function automatic logic edo_release(input edo_strobe_t s, input logic lane_cas_n);
        return (!s.we_n) || s.outen_n || (lane_cas_n && s.ras_n);
    endfunction

    // Read access qualifier, excluding the column edge itself.
    function automatic logic edo_read_ok(input edo_strobe_t s, input logic in_refresh);
        return (!s.ras_n) && (!s.outen_n) && s.we_n && !in_refresh;
    endfunction

endpackage

// File: rtl/edo_cycle_track.sv
// Module: edo_cycle_track
// Classifies each row-strobe-low period: it notes whether the period began
// as a refresh (column strobe already low at the row fall) and whether a read
// access has opened the page. Both flags clear when the row strobe is high.
// Assumes strobes are synchronous to clk; reset is synchronous active low.
module edo_cycle_track #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic [LANES-1:0] acc_evt,
    output logic             refresh_now,
    output logic             page_open
);

    logic             ras_q;
    logic [LANES-1:0] cas_q;
    logic             ref_flag;
    logic             ras_fall;
    logic             cas_held_low;

    // Previous sampled strobe levels, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= '1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    // Row fall, and whether some column strobe was low before and after it.
    always_comb begin
        ras_fall     = ras_q && !ras_n;
        cas_held_low = |((~cas_q) & (~cas_n));
    end

    // Refresh is in force from the refresh-type row fall to the row rise.
    always_comb begin
        refresh_now = ref_flag || (ras_fall && cas_held_low);
    end

    // Refresh flag register for the rest of the row-low period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_flag <= 1'b0;
        end else if (ras_n) begin
            ref_flag <= 1'b0;
        end else if (ras_fall && cas_held_low) begin
            ref_flag <= 1'b1;
        end
    end

    // Page-open flag: set by the first read access of a row-low period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_open <= 1'b0;
        end else if (ras_n) begin
            page_open <= 1'b0;
        end else if (|acc_evt) begin
            page_open <= 1'b1;
        end
    end

endmodule

// File: rtl/edo_lane_ctl.sv
// Module: edo_lane_ctl
// One byte lane: enables the lane on a qualified falling column strobe and
// captures the lane byte. It holds the byte after the strobe rises (extended
// data out) and drops the enable on a release condition. While the page is
// open, a column-valid pulse recaptures the byte early.
// Assumes strobes are synchronous to clk; reset is synchronous active low.
module edo_lane_ctl
    import edo_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cas_n,
    input  edo_strobe_t       stb,
    input  logic              refresh_now,
    input  logic              page_open,
    input  logic [LANE_W-1:0] rd_lane,
    output logic              oe,
    output logic [LANE_W-1:0] data,
    output logic              acc_evt
);

    logic cas_q;
    logic cas_fall;
    logic rel;
    logic early;

    // Previous column strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_q <= 1'b1;
        end else begin
            cas_q <= cas_n;
        end
    end

    // Decode access, release and early recapture for this lane.
    always_comb begin
        cas_fall = cas_q && !cas_n;
        acc_evt  = cas_fall && edo_read_ok(stb, refresh_now);
        rel      = edo_release(stb, cas_n);
        early    = oe && page_open && stb.col_vld;
    end

    // Enable register: release wins, then a new access sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe <= 1'b0;
        end else if (rel) begin
            oe <= 1'b0;
        end else if (acc_evt) begin
            oe <= 1'b1;
        end
    end

    // Data register: captured on access or early recapture, else held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (!rel && (acc_evt || early)) begin
            data <= rd_lane;
        end
    end

endmodule

// File: rtl/edo_read_ctl.sv
// Module: edo_read_ctl (top)
// EDO read output enable control for a bus split into byte lanes. Lane i
// follows column strobe cas_n[i] and owns bits [i*LANE_W +: LANE_W].
// Assumes every input is synchronous to clk; reset is synchronous active low.
module edo_read_ctl
    import edo_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    input  logic             outen_n,
    input  logic             we_n,
    input  logic             col_vld,
    input  logic [BUS_W-1:0] rd_data,
    output logic [BUS_W-1:0] dq_out,
    output logic [LANES-1:0] dq_oe
);

    edo_strobe_t      stb;
    logic             refresh_now;
    logic             page_open;
    logic [LANES-1:0] acc_evt;

    // Gather the shared strobes.
    always_comb begin
        stb.ras_n   = ras_n;
        stb.outen_n = outen_n;
        stb.we_n    = we_n;
        stb.col_vld = col_vld;
    end

    edo_cycle_track #(
        .LANES(LANES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .acc_evt    (acc_evt),
        .refresh_now(refresh_now),
        .page_open  (page_open)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edo_lane_ctl #(
            .LANE_W(LANE_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .cas_n      (cas_n[g]),
            .stb        (stb),
            .refresh_now(refresh_now),
            .page_open  (page_open),
            .rd_lane    (rd_data[g*LANE_W +: LANE_W]),
            .oe         (dq_oe[g]),
            .data       (dq_out[g*LANE_W +: LANE_W]),
            .acc_evt    (acc_evt[g])
        );
    end

endmodule

// File: rtl/edo_read_ctl_chk.sv
// Module: edo_read_ctl_chk
// Property checker for edo_read_ctl, attached by bind. It watches the ports
// and the refresh classification from the cycle tracker.
module edo_read_ctl_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             outen_n,
    input logic             we_n,
    input logic [BUS_W-1:0] rd_data,
    input logic [BUS_W-1:0] dq_out,
    input logic [LANES-1:0] dq_oe,
    input logic             refresh_now
);

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (dq_oe == '0)); // R1

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_READ_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(cas_n[g]) && !ras_n && !outen_n && we_n && !refresh_now |=> dq_oe[g]); // R2

        AST_DATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dq_oe[g]) |-> dq_out[g*LANE_W +: LANE_W] == $past(rd_data[g*LANE_W +: LANE_W])); // R2

        AST_EDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            dq_oe[g] && we_n && !outen_n && !(cas_n[g] && ras_n) |=> dq_oe[g]); // R3

        AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
            (!we_n || outen_n || (cas_n[g] && ras_n)) |=> !dq_oe[g]); // R4

        AST_NO_ENABLE_ROW_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            ras_n && !dq_oe[g] |=> !dq_oe[g]); // R7

        AST_REFRESH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            refresh_now && !dq_oe[g] |=> !dq_oe[g]); // R8
    end

endmodule

bind edo_read_ctl edo_read_ctl_chk #(
    .LANES (LANES),
    .LANE_W(LANE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .outen_n    (outen_n),
    .we_n       (we_n),
    .rd_data    (rd_data),
    .dq_out     (dq_out),
    .dq_oe      (dq_oe),
    .refresh_now(refresh_now)
);

// File: tb/edo_read_ctl_bench.sv
`timescale 1ns/1ps
module edo_read_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ras_n;
    logic [1:0]  cas_n;
    logic        outen_n;
    logic        we_n;
    logic        col_vld;
    logic [15:0] rd_data;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [1:0]  oe;
        logic [15:0] dq;
        logic [15:0] mask;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    edo_read_ctl u_edo_read_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .outen_n(outen_n),
        .we_n   (we_n),
        .col_vld(col_vld),
        .rd_data(rd_data),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    // Driver: apply one cycle of strobes and queue the result due after the next edge.
    task automatic drv(input logic r, input logic [1:0] c, input logic t, input logic w,
                       input logic cv, input logic [15:0] rd,
                       input logic [1:0] eoe, input logic [15:0] edq, input string tag);
        exp_t e;
        @(negedge clk);
        ras_n = r; cas_n = c; outen_n = t; we_n = w; col_vld = cv; rd_data = rd;
        e.oe   = eoe;
        e.dq   = edq;
        e.mask = {{8{eoe[1]}}, {8{eoe[0]}}};
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare each queued expectation just after its clock edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (dq_oe !== e.oe || (dq_out & e.mask) !== (e.dq & e.mask)) begin
                n_fail++;
                $display("FAIL %s: oe=%b dq=%h expected oe=%b dq=%h (mask %h)",
                         e.tag, dq_oe, dq_out, e.oe, e.dq, e.mask);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ras_n = 1'b1; cas_n = 2'b11; outen_n = 1'b0; we_n = 1'b1;
        col_vld = 1'b0; rd_data = 16'hDEAD;
        repeat (4) @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (dq_oe !== 2'b00 || dq_out !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1 reset: oe=%b dq=%h expected oe=00 dq=0000", dq_oe, dq_out);
        end
        rst_n = 1'b1;

        // R2 R3 R4: single read, hold after column rise, release on both strobes high.
        drv(0, 2'b11, 0, 1, 0, 16'h0F0F, 2'b00, 16'h0, "R10 row low, columns high");
        drv(0, 2'b00, 0, 1, 0, 16'hA1B2, 2'b11, 16'hA1B2, "R2 read enable and capture");
        drv(0, 2'b11, 0, 1, 0, 16'hFFFF, 2'b11, 16'hA1B2, "R3 hold after column rise");
        drv(1, 2'b11, 0, 1, 0, 16'hFFFF, 2'b00, 16'h0, "R4 release on row and column high");

        // R2: lanes follow their own strobes.
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R2 idle row");
        drv(0, 2'b10, 0, 1, 0, 16'h1234, 2'b01, 16'h0034, "R2 lane 0 alone");
        drv(0, 2'b00, 0, 1, 0, 16'h5678, 2'b11, 16'h5634, "R2 lane 1 joins, lane 0 held");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R4 both lanes released");

        // R5: page-mode recapture on a new column fall.
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R5 open row");
        drv(0, 2'b00, 0, 1, 0, 16'h1111, 2'b11, 16'h1111, "R5 first column");
        drv(0, 2'b11, 0, 1, 0, 16'h2222, 2'b11, 16'h1111, "R5 column high holds");
        drv(0, 2'b00, 0, 1, 0, 16'h3333, 2'b11, 16'h3333, "R5 second column recapture");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R5 close row");

        // R6: early capture on column-valid inside an open page only.
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R6 open row");
        drv(0, 2'b00, 0, 1, 0, 16'h4444, 2'b11, 16'h4444, "R6 access opens page");
        drv(0, 2'b11, 0, 1, 1, 16'h5555, 2'b11, 16'h5555, "R6 early recapture");
        drv(0, 2'b11, 0, 1, 0, 16'h6666, 2'b11, 16'h5555, "R6 held without pulse");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R6 close row");
        drv(0, 2'b11, 0, 1, 1, 16'h7777, 2'b00, 16'h0, "R6 pulse with closed page ignored");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R6 idle");

        // R7: unqualified column falls do not enable.
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R7 open row");
        drv(0, 2'b00, 0, 0, 0, 16'h8888, 2'b00, 16'h0, "R7 write-strobe low");
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R7 columns up");
        drv(0, 2'b00, 1, 1, 0, 16'h8888, 2'b00, 16'h0, "R7 gate high");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R7 row up");
        drv(1, 2'b00, 0, 1, 0, 16'h8888, 2'b00, 16'h0, "R7 row high");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R7 idle");

        // R11 R4: read-modify-write and gate release.
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R11 open row");
        drv(0, 2'b00, 0, 1, 0, 16'h9A9A, 2'b11, 16'h9A9A, "R11 read phase");
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b11, 16'h9A9A, "R11 held before write");
        drv(0, 2'b11, 0, 0, 0, 16'h0000, 2'b00, 16'h0, "R11 write-strobe releases");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R11 idle");
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R4 open row");
        drv(0, 2'b00, 0, 1, 0, 16'hABCD, 2'b11, 16'hABCD, "R4 read");
        drv(0, 2'b00, 1, 1, 0, 16'h0000, 2'b00, 16'h0, "R4 gate high releases");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R4 idle");

        // R8: refresh row blocks reads until the row rises.
        drv(1, 2'b00, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R8 columns first");
        drv(0, 2'b00, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R8 refresh row fall");
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R8 columns up");
        drv(0, 2'b00, 0, 1, 0, 16'h1357, 2'b00, 16'h0, "R8 read blocked in refresh");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R8 row up");
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R8 normal row");
        drv(0, 2'b00, 0, 1, 0, 16'h2468, 2'b11, 16'h2468, "R8 read after refresh");

        // R9: hidden refresh keeps the live read.
        drv(1, 2'b00, 0, 1, 0, 16'hFFFF, 2'b11, 16'h2468, "R9 row up, columns low");
        drv(0, 2'b00, 0, 1, 0, 16'hFFFF, 2'b11, 16'h2468, "R9 refresh row fall");
        drv(1, 2'b00, 0, 1, 0, 16'hFFFF, 2'b11, 16'h2468, "R9 row up again");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R9 final release");

        // R10: row-only refresh keeps lanes off.
        drv(0, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R10 row-only low");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R10 row-only high");
        drv(0, 2'b11, 1, 1, 0, 16'h0000, 2'b00, 16'h0, "R10 row-only low, gate high");
        drv(1, 2'b11, 0, 1, 0, 16'h0000, 2'b00, 16'h0, "R10 idle");

        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule